// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This block sets how long a requester waits before retrying a contended atomic operation. Each time the requester reports a failed attempt, the block issues one wait request to a pause unit. The length of that request grows exponentially with the number of consecutive failures. A success report ends the operation, and the next failure starts a fresh operation with the shortest wait.

The block holds a backoff level that is 1 at the start of an operation. The scaler multiplies the level by 128 to form the wait length, and the whole wait goes out as a single request. The level doubles only when the pause unit accepts a request, and only if the level does not already exceed a ceiling of 4096. It therefore steps through 1, 2, 4, ..., 4096, 8192 and then stays at 8192.

The controller has three named states. IDLE means no operation is in progress. ARMED means an operation is in progress and no request is outstanding. REQ means a wait request is being presented.

Its transitions are as follows:
- IDLE→REQ on a failure (called *start*).
- ARMED→REQ on a failure (called *retry*).
- REQ→ARMED when the pause unit accepts (called *accept*).
- Any state→IDLE on success (called *clear*).

Top module: `backoff_ctrl`

## Requirements
- R1: Synchronous active-high reset puts the block in IDLE with `pause_valid_o` low, `pause_cycles_o` zero and the level at 1, so the first failure after reset requests 128 cycles.
- R2: A failure sampled in IDLE or ARMED (with `success_i` low) makes `pause_valid_o` high in the next cycle.
- R3: When a request is accepted (`pause_valid_o` and `pause_ready_i` both high), the level doubles if it is at most 4096 and is otherwise unchanged. Successive requests of one operation therefore ask for 128·{1,2,4,…,4096,8192,8192,…} cycles.
- R4: While `pause_valid_o` is high, `pause_cycles_o` equals the level shifted left by 7 bits, sent as one value. Its low 7 bits are zero, exactly one bit is set, and the value never exceeds 8192·128 on the 21-bit output.
- R5: An unaccepted request keeps `pause_valid_o` high with `pause_cycles_o` unchanged. After acceptance, `pause_valid_o` is low in the next cycle.
- R6: A failure sampled while `pause_valid_o` is high has no effect on the current request or on the length of the following one.
- R7: `success_i` takes priority over `fail_i` and returns the block to IDLE. It withdraws any pending request in the next cycle, and the next failure requests 128 cycles.
- R8: `pause_cycles_o` is zero whenever `pause_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_i | input | 1 | One-cycle report of a failed attempt |
| success_i | input | 1 | One-cycle report that the operation completed |
| pause_ready_i | input | 1 | Pause unit accepts the current request |
| pause_valid_o | output | 1 | Wait request is being presented |
| pause_cycles_o | output | 21 | Requested wait length in cycles |

## Verification
Each sweep drives one operation through twenty consecutive failures. This walks the level from 1 past the ceiling into saturation. It separates a ceiling test of "greater than" from one of "greater or equal" by whether the request after 4096·128 is 8192·128. Acceptance delays vary from zero to three cycles, and spurious failures are injected on alternate waits. This shows that a held request is stable and that an ignored failure does not add a doubling. Success is applied between requests, during a pending request, and in the same cycle as a failure. Reset is applied mid-operation. These cases show that each path restarts at 128 cycles.

// File: rtl/bo_pkg.sv
package bo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_REQ   = 2'd2
    } bo_state_e;
endpackage

// File: rtl/bo_fsm.sv
module bo_fsm
    import bo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fail,
    input  logic success,
    input  logic ready,
    output logic req,
    output logic load_one,
    output logic grow
);
    bo_state_e state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions: start, retry, accept, clear
    always_comb begin
        nxt = state;
        if (success) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (fail)  nxt = ST_REQ;
                ST_ARMED: if (fail)  nxt = ST_REQ;
                ST_REQ:   if (ready) nxt = ST_ARMED;
                default:             nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        req      = 1'b0;
        load_one = success;
        grow     = 1'b0;
        unique case (state)
            ST_IDLE:  load_one = success | fail;
            ST_ARMED: ;
            ST_REQ: begin
                req  = 1'b1;
                grow = ready & ~success;
            end
            default:  load_one = 1'b1;
        endcase
    end
endmodule

// File: rtl/bo_level.sv
module bo_level #(
    parameter int VAL_W = 14,
    parameter int LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_one,
    input  logic             grow,
    output logic [VAL_W-1:0] level_o
);
    localparam logic [VAL_W-1:0] CEIL = VAL_W'(LIMIT);
    localparam logic [VAL_W-1:0] ONE  = VAL_W'(1);

    logic above;
    assign above = (level_o > CEIL);

    always_ff @(posedge clk) begin
        if (rst || load_one)
            level_o <= ONE;
        else if (grow && !above)
            level_o <= level_o << 1;
    end
endmodule

// File: rtl/bo_scale.sv
module bo_scale #(
    parameter int VAL_W = 14,
    parameter int SHIFT = 7,
    localparam int CYC_W = VAL_W + SHIFT
) (
    input  logic [VAL_W-1:0] level,
    input  logic             en,
    output logic [CYC_W-1:0] cycles_o
);
    generate
        if (SHIFT > 0) begin : g_shift
            assign cycles_o = en ? {level, {SHIFT{1'b0}}} : '0;
        end else begin : g_plain
            assign cycles_o = en ? level : '0;
        end
    endgenerate
endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl #(
    parameter int VAL_W = 14,
    parameter int SHIFT = 7,
    parameter int LIMIT = 4096,
    localparam int CYC_W = VAL_W + SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_i,
    input  logic             success_i,
    input  logic             pause_ready_i,
    output logic             pause_valid_o,
    output logic [CYC_W-1:0] pause_cycles_o
);
    logic             load_one;
    logic             grow;
    logic [VAL_W-1:0] level;

    bo_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .fail     (fail_i),
        .success  (success_i),
        .ready    (pause_ready_i),
        .req      (pause_valid_o),
        .load_one (load_one),
        .grow     (grow)
    );

    bo_level #(.VAL_W(VAL_W), .LIMIT(LIMIT)) u_level (
        .clk      (clk),
        .rst      (rst),
        .load_one (load_one),
        .grow     (grow),
        .level_o  (level)
    );

    bo_scale #(.VAL_W(VAL_W), .SHIFT(SHIFT)) u_scale (
        .level    (level),
        .en       (pause_valid_o),
        .cycles_o (pause_cycles_o)
    );
endmodule

// File: rtl/bo_checker.sv
module bo_checker #(
    parameter int VAL_W = 14,
    parameter int SHIFT = 7,
    parameter int LIMIT = 4096,
    localparam int CYC_W = VAL_W + SHIFT
) (
    input logic             clk,
    input logic             rst,
    input logic             fail_i,
    input logic             success_i,
    input logic             pause_ready_i,
    input logic             pause_valid_o,
    input logic [CYC_W-1:0] pause_cycles_o
);
    localparam logic [CYC_W-1:0] MAXC = CYC_W'(2 * LIMIT) << SHIFT;
    localparam logic [CYC_W-1:0] CEILC = CYC_W'(LIMIT) << SHIFT;
    localparam logic [CYC_W-1:0] FIRST = CYC_W'(1) << SHIFT;

    logic             have_prev;
    logic [CYC_W-1:0] last_acc;

    always_ff @(posedge clk) begin
        if (rst || success_i) begin
            have_prev <= 1'b0;
            last_acc  <= '0;
        end else if (pause_valid_o && pause_ready_i) begin
            have_prev <= 1'b1;
            last_acc  <= pause_cycles_o;
        end
    end

    a_r2_issue: assert property (@(posedge clk) disable iff (rst)
        (fail_i && !success_i && !pause_valid_o) |=> pause_valid_o);

    a_r3_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(pause_valid_o) && !have_prev) |-> (pause_cycles_o == FIRST));

    a_r3_growth: assert property (@(posedge clk) disable iff (rst)
        ($rose(pause_valid_o) && have_prev) |->
        (pause_cycles_o == ((last_acc > CEILC) ? last_acc : (last_acc << 1))));

    a_r4_shape: assert property (@(posedge clk) disable iff (rst)
        pause_valid_o |-> ($onehot(pause_cycles_o) && pause_cycles_o <= MAXC
                           && pause_cycles_o >= FIRST));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (pause_valid_o && !pause_ready_i && !success_i) |=>
        (pause_valid_o && $stable(pause_cycles_o)));

    a_r5_drop: assert property (@(posedge clk) disable iff (rst)
        (pause_valid_o && pause_ready_i) |=> !pause_valid_o);

    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        success_i |=> !pause_valid_o);

    a_r8_zero: assert property (@(posedge clk) disable iff (rst)
        !pause_valid_o |-> (pause_cycles_o == '0));
endmodule

bind backoff_ctrl bo_checker #(.VAL_W(VAL_W), .SHIFT(SHIFT), .LIMIT(LIMIT)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .fail_i         (fail_i),
    .success_i      (success_i),
    .pause_ready_i  (pause_ready_i),
    .pause_valid_o  (pause_valid_o),
    .pause_cycles_o (pause_cycles_o)
);

// File: tb/tb_backoff_ctrl.sv
`timescale 1ns/1ps
module tb_backoff_ctrl;
    localparam int CW = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fail_i = 1'b0;
    logic          success_i = 1'b0;
    logic          pause_ready_i = 1'b0;
    logic          pause_valid_o;
    logic [CW-1:0] pause_cycles_o;

    int n_chk = 0;
    int n_bad = 0;
    int e = 1;
    bit done = 1'b0;

    always #5 clk = ~clk;

    backoff_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .fail_i         (fail_i),
        .success_i      (success_i),
        .pause_ready_i  (pause_ready_i),
        .pause_valid_o  (pause_valid_o),
        .pause_cycles_o (pause_cycles_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // one failed attempt: request, wait `delay` cycles (with optional spurious fails), accept
    task automatic attempt(input int delay, input bit poke);
        fail_i = 1'b1;
        step();
        fail_i = 1'b0;
        check(pause_valid_o == 1'b1, "R2 valid after fail", pause_valid_o, 1);
        check(pause_cycles_o == CW'(e * 128), "R4/R3 wait length", pause_cycles_o, e * 128);
        for (int d = 0; d < delay; d++) begin
            fail_i = poke;
            step();
            fail_i = 1'b0;
            check(pause_valid_o == 1'b1, "R5 held valid", pause_valid_o, 1);
            check(pause_cycles_o == CW'(e * 128), "R6 held length", pause_cycles_o, e * 128);
        end
        pause_ready_i = 1'b1;
        step();
        pause_ready_i = 1'b0;
        check(pause_valid_o == 1'b0, "R5 drop after accept", pause_valid_o, 0);
        check(pause_cycles_o == '0, "R8 zero when idle", pause_cycles_o, 0);
        if (e <= 4096) e = e * 2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        step();
        step();
        rst = 1'b0;
        check(pause_valid_o == 1'b0, "R1 reset valid", pause_valid_o, 0);
        check(pause_cycles_o == '0, "R1 reset length", pause_cycles_o, 0);

        // R3 sweep through the ceiling into saturation
        e = 1;
        for (int i = 0; i < 20; i++) attempt(i % 4, (i % 2) == 1);
        check(e == 8192, "R3 saturated level", e, 8192);

        // R7 success between requests
        success_i = 1'b1;
        step();
        success_i = 1'b0;
        check(pause_valid_o == 1'b0, "R7 idle after success", pause_valid_o, 0);
        e = 1;
        attempt(1, 1'b0);
        attempt(0, 1'b1);

        // R7 success during a pending request
        fail_i = 1'b1;
        step();
        fail_i = 1'b0;
        check(pause_valid_o == 1'b1, "R2 pending before clear", pause_valid_o, 1);
        success_i = 1'b1;
        step();
        success_i = 1'b0;
        check(pause_valid_o == 1'b0, "R7 request withdrawn", pause_valid_o, 0);
        check(pause_cycles_o == '0, "R8 zero after withdraw", pause_cycles_o, 0);
        e = 1;
        attempt(2, 1'b1);

        // R7 success and fail together: success wins
        success_i = 1'b1;
        fail_i = 1'b1;
        step();
        success_i = 1'b0;
        fail_i = 1'b0;
        check(pause_valid_o == 1'b0, "R7 success priority", pause_valid_o, 0);
        step();
        check(pause_valid_o == 1'b0, "R7 still idle", pause_valid_o, 0);
        e = 1;
        attempt(0, 1'b0);

        // R1 reset mid-operation
        for (int i = 0; i < 4; i++) attempt(1, 1'b0);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(pause_valid_o == 1'b0, "R1 valid after reset", pause_valid_o, 0);
        e = 1;
        attempt(0, 1'b0);
        check(e == 2, "R1 restart level", e, 2);

        finish_run();
    end
endmodule